// File: doc/BRIEF.md
# Reload Timer with Buffered PWM

A 16-bit up-counter driven by a byte-wide register port. When enabled in continuous mode it counts up one step per clock. When it reaches a programmed 16-bit limit, it restarts at 0001H rather than at zero. A single PWM output compares the running count against an active threshold. Software writes to that threshold go into a shadow copy while the timer runs, and reach the comparator only on the next restart. A control bit lets the writes take effect at once instead.

Two more modes reuse the same registers. In compare mode the limit bytes act as a match value. The counter runs to FFFFH and restarts at 0001H, and the output toggles on every match. In capture mode a synchronised external input stores the running count into the threshold register pair on the chosen edge, and a one-cycle flag is raised. A one-cycle pulse marks every restart at 0001H.

Register map on the 3-bit byte address: 0 control, 1 limit high byte, 2 limit low byte, 3 threshold high byte, 4 threshold low byte, 5 count high byte, 6 count low byte, 7 reads 00H. The count bytes are read-only.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset: control reads 00H, limit reads FFFFH, threshold reads 0000H, count reads 0001H, and `pwm_out`, `reload_pulse` and `capture_flag` are 0.
- R2: The limit is {byte at address 1, byte at address 2}. Each byte can be written and read back on its own.
- R3: Control bit 0 (run) enables counting. Mode field bits [2:1] select the mode: 00 continuous, 01 compare, 10 capture, 11 behaves as continuous. In continuous and capture modes the count steps by one per clock, and it reaches 0001H on the clock after it equals the limit or FFFFH. `reload_pulse` is high exactly in the cycle after each such restart. With run clear, the count holds.
- R4: In continuous mode with run set, `pwm_out` equals (count < active threshold) XOR control bit 3 (invert). With run clear, and in capture mode, `pwm_out` equals bit 3.
- R5: With run set and control bit 4 (immediate) clear, a threshold byte write changes only the shadow copy. Reads of addresses 3/4 keep returning the old active value until the restart, and the new value appears together with count 0001H.
- R6: With run clear or bit 4 set, a threshold byte write reaches the active value, and readback, on the next cycle.
- R7: In compare mode the count runs to FFFFH and then restarts at 0001H with `reload_pulse`. The output state toggles on each clock at which the count equals the limit, so the change is visible while the count reads limit+1. `pwm_out` = state XOR bit 3, and the state clears while run is clear.
- R8: In capture mode with run set, `cap_in` passes through two synchronising flops. On a rising edge (control bit 5 = 0) or a falling edge (bit 5 = 1), the active threshold takes the count of the third clock after the input change, and `capture_flag` is high for one cycle. The other edge is ignored.
- R9: Address 0 reads back the control byte as written, and address 7 reads 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte register select |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | PWM / compare output |
| reload_pulse | output | 1 | One-cycle restart marker |
| capture_flag | output | 1 | One-cycle capture marker |

## Verification
The hardest situation to reach is a buffered threshold write that is still pending when the restart occurs. This needs the run bit set, the immediate bit clear, and a write that lands some cycles before the count reaches a small limit. The bench programs a limit of 0008H, writes the threshold while running, and then reads it back every cycle. It expects the old value on each cycle up to the restart and the new value on the cycle when the count reads 0001H. The capture path is timed the same way: the count is read one cycle before the capture clock, and that value is expected in the threshold register on the next cycle.

// File: rtl/tmr_pkg.sv
// Shared widths, register addresses and control layout for the reload timer.
// Assumes a 16-bit count split into two bytes.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_THR_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_THR_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd6;

    typedef enum logic [1:0] {
        MODE_CONT = 2'b00,
        MODE_CMP  = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_RSV  = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic [1:0] rsvd;      // bits 7:6, stored only
        logic       cap_fall;  // bit 5
        logic       imm_upd;   // bit 4
        logic       inv;       // bit 3
        tmr_mode_e  mode;      // bits 2:1
        logic       run;       // bit 0
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
// Synchronises an asynchronous input through STAGES flops and reports
// rising and falling edges of the synchronised level, one cycle each.
// Assumes STAGES >= 2.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    // Compare the synchronised level with its previous value.
    always_comb begin
        rise = pipe[STAGES-1] & ~pipe[STAGES];
        fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/tmr_counter.sv
// Up-counter that restarts at CNT_START when it equals the limit (except in
// compare mode) or reaches CNT_MAX. Emits a registered pulse after each restart.
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cmp_mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             reload_pulse
);
    // Restart condition for the coming clock edge.
    always_comb begin
        wrap = run && ((count == CNT_MAX) || (!cmp_mode && count == limit));
    end

    // Advance, restart or hold the count; register the restart marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= CNT_START;
            reload_pulse <= 1'b0;
        end else begin
            reload_pulse <= wrap;
            if (wrap)     count <= CNT_START;
            else if (run) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_pwm_regs.sv
// Threshold register pair with shadow copy. Byte writes always land in the
// shadow; the active value follows on a direct write or at a restart.
// A capture overwrites both copies and takes priority over writes.
module tmr_pwm_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              direct,
    input  logic              reload_evt,
    input  logic              cap_evt,
    input  logic [CNT_W-1:0]  cap_val,
    output logic [CNT_W-1:0]  active
);
    logic [CNT_W-1:0] shadow, shadow_nxt;

    // Merge this cycle's byte writes into the shadow value.
    always_comb begin
        shadow_nxt = shadow;
        if (wr_hi) shadow_nxt[CNT_W-1:BYTE_W] = wdata;
        if (wr_lo) shadow_nxt[BYTE_W-1:0]     = wdata;
    end

    // Update shadow and active copies by priority: capture, then write/restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else if (cap_evt) begin
            shadow <= cap_val;
            active <= cap_val;
        end else begin
            shadow <= shadow_nxt;
            if ((direct && (wr_hi || wr_lo)) || reload_evt) active <= shadow_nxt;
        end
    end
endmodule

// File: rtl/reload_pwm_timer.sv
// Top level: register port, counter, shadowed threshold, capture path and
// output logic. Reads are combinational; writes take effect at the clock edge.
module reload_pwm_timer
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              pwm_out,
    output logic              reload_pulse,
    output logic              capture_flag
);
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] thr_act;
    logic             wrap, rise, fall, cap_evt, toggle_q, level;
    logic             is_cmp, is_cap;

    // Control and limit register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            limit_q <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   ctrl_q                  <= tmr_ctrl_t'(bus_wdata);
                A_LIM_HI: limit_q[CNT_W-1:BYTE_W] <= bus_wdata;
                A_LIM_LO: limit_q[BYTE_W-1:0]     <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Mode decode and capture qualification.
    always_comb begin
        is_cmp  = (ctrl_q.mode == MODE_CMP);
        is_cap  = (ctrl_q.mode == MODE_CAP);
        cap_evt = ctrl_q.run && is_cap && (ctrl_q.cap_fall ? fall : rise);
    end

    tmr_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (ctrl_q.run),
        .cmp_mode     (is_cmp),
        .limit        (limit_q),
        .count        (count),
        .wrap         (wrap),
        .reload_pulse (reload_pulse)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .rise  (rise),
        .fall  (fall)
    );

    tmr_pwm_regs u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (bus_wr && bus_addr == A_THR_HI),
        .wr_lo      (bus_wr && bus_addr == A_THR_LO),
        .wdata      (bus_wdata),
        .direct     (!ctrl_q.run || ctrl_q.imm_upd),
        .reload_evt (wrap),
        .cap_evt    (cap_evt),
        .cap_val    (count),
        .active     (thr_act)
    );

    // Capture marker and compare-mode toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture_flag <= 1'b0;
            toggle_q     <= 1'b0;
        end else begin
            capture_flag <= cap_evt;
            if (!ctrl_q.run)                   toggle_q <= 1'b0;
            else if (is_cmp && count == limit_q) toggle_q <= ~toggle_q;
        end
    end

    // Output level by mode, then polarity.
    always_comb begin
        if (!ctrl_q.run)  level = 1'b0;
        else if (is_cmp)  level = toggle_q;
        else if (is_cap)  level = 1'b0;
        else              level = (count < thr_act);
        pwm_out = level ^ ctrl_q.inv;
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_LIM_HI: bus_rdata = limit_q[CNT_W-1:BYTE_W];
            A_LIM_LO: bus_rdata = limit_q[BYTE_W-1:0];
            A_THR_HI: bus_rdata = thr_act[CNT_W-1:BYTE_W];
            A_THR_LO: bus_rdata = thr_act[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = count[BYTE_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Temporal checks on the reload timer, attached by bind.
module tmr_checker
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             inv,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] thr_act,
    input logic             pwm_out,
    input logic             reload_pulse,
    input logic             capture_flag
);
    AST_LIMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode != 2'b01 && count == limit) |=> (count == CNT_START)); // R3
    AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> (count == CNT_START)); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count)); // R3
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == inv)); // R4
    AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_flag |=> !capture_flag); // R8
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_flag |-> (thr_act == $past(count))); // R8
endmodule

bind reload_pwm_timer tmr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (ctrl_q.run),
    .inv          (ctrl_q.inv),
    .mode         (ctrl_q.mode),
    .count        (count),
    .limit        (limit_q),
    .thr_act      (thr_act),
    .pwm_out      (pwm_out),
    .reload_pulse (reload_pulse),
    .capture_flag (capture_flag)
);

// File: tb/sim_reload_pwm_timer.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_reload_pwm_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cap_in = 1'b0;
    logic       pwm_out, reload_pulse, capture_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .pwm_out(pwm_out), .reload_pulse(reload_pulse), .capture_flag(capture_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] hi, output logic [15:0] v);
        logic [7:0] h, l;
        rd(hi, h);
        rd(hi + 3'd1, l);
        v = {h, l};
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [15:0] v;
        rd(3'd0, b);   chk(b == 8'h00, "R1 ctrl", b, 0);
        rd16(3'd1, v); chk(v == 16'hFFFF, "R1 limit", v, 16'hFFFF);
        rd16(3'd3, v); chk(v == 16'h0000, "R1 threshold", v, 0);
        rd16(3'd5, v); chk(v == 16'h0001, "R1 count", v, 1);
        chk({pwm_out, reload_pulse, capture_flag} == 3'b000, "R1 outputs",
            {pwm_out, reload_pulse, capture_flag}, 0);
        rd(3'd7, b);   chk(b == 8'h00, "R9 addr7", b, 0);
    endtask

    task automatic t_limit_regs();
        logic [15:0] v; logic [7:0] b;
        wr(3'd1, 8'h12); wr(3'd2, 8'h34);
        rd16(3'd1, v); chk(v == 16'h1234, "R2 limit bytes", v, 16'h1234);
        wr(3'd0, 8'hC8);
        rd(3'd0, b); chk(b == 8'hC8, "R9 ctrl readback", b, 8'hC8);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_continuous();
        logic [15:0] v, expc; bit ok, pok, lok; int pulses = 0;
        wr(3'd1, 8'h00); wr(3'd2, 8'h05);
        wr(3'd3, 8'h00); wr(3'd4, 8'h03);
        rd16(3'd3, v); chk(v == 16'h0003, "R6 direct write while stopped", v, 3);
        rd16(3'd5, expc);
        wr(3'd0, 8'h01);
        ok = 1; pok = 1; lok = 1;
        for (int i = 0; i < 14; i++) begin
            bit ep;
            ep = (expc == 16'h0005 || expc == 16'hFFFF);
            expc = ep ? 16'h0001 : expc + 16'h1;
            step();
            rd16(3'd5, v);
            if (v != expc) ok = 0;
            if (reload_pulse != ep) pok = 0;
            if (pwm_out != (expc < 16'h0003)) lok = 0;
            if (ep) pulses++;
        end
        chk(ok, "R3 continuous count sequence", v, expc);
        chk(pok && pulses > 0, "R3 reload pulse timing", pulses, 1);
        chk(lok, "R4 pwm level vs threshold", pwm_out, expc < 3);
        wr(3'd0, 8'h00);
        rd16(3'd5, expc);
        repeat (3) step();
        rd16(3'd5, v); chk(v == expc, "R3 hold when stopped", v, expc);
        chk(pwm_out == 1'b0, "R4 idle level", pwm_out, 0);
        wr(3'd0, 8'h08);
        chk(pwm_out == 1'b1, "R4 inverted idle level", pwm_out, 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_buffered();
        logic [15:0] v, c; bit ok = 1; bit seen = 0;
        wr(3'd1, 8'h00); wr(3'd2, 8'h08);
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h06);
        for (int i = 0; i < 20 && !seen; i++) begin
            rd16(3'd5, c); rd16(3'd3, v);
            if (reload_pulse && c == 16'h0001) begin
                seen = 1;
                chk(v == 16'h0006, "R5 new value at restart", v, 6);
            end else if (v != 16'h0003) ok = 0;
            if (!seen) step();
        end
        chk(ok, "R5 old value held before restart", v, 3);
        chk(seen, "R5 restart reached", seen, 1);
        wr(3'd0, 8'h11);
        wr(3'd4, 8'h02);
        rd16(3'd3, v); chk(v == 16'h0002, "R6 immediate update while running", v, 2);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_compare();
        logic [15:0] v, expc; bit tog = 0; bit ok = 1; bit wrapped = 0; bit toggled = 0;
        wr(3'd1, 8'h00); wr(3'd2, 8'h10);
        rd16(3'd5, expc);
        wr(3'd0, 8'h03);
        for (int i = 0; i < 70000 && !(wrapped && toggled); i++) begin
            bit ep;
            ep = (expc == 16'hFFFF);
            if (expc == 16'h0010) begin tog = ~tog; if (wrapped) toggled = 1; end
            expc = ep ? 16'h0001 : expc + 16'h1;
            step();
            rd16(3'd5, v);
            if (v != expc || reload_pulse != ep || pwm_out != tog) ok = 0;
            if (ep) wrapped = 1;
        end
        chk(ok, "R7 compare count, restart and toggle", v, expc);
        chk(wrapped && toggled, "R7 full wrap and match seen", {wrapped, toggled}, 3);
        wr(3'd0, 8'h00);
        chk(pwm_out == 1'b0, "R7 toggle state cleared when stopped", pwm_out, 0);
    endtask

    task automatic capture_one(input string req);
        logic [15:0] v, t;
        step();
        step();
        rd16(3'd5, v);
        chk(capture_flag == 1'b0, req, capture_flag, 0);
        step();
        rd16(3'd3, t);
        chk(capture_flag == 1'b1, req, capture_flag, 1);
        chk(t == v, req, t, v);
        step();
        chk(capture_flag == 1'b0, req, capture_flag, 0);
    endtask

    task automatic t_capture();
        logic [15:0] t0, t; bit quiet = 1;
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h05);
        chk(pwm_out == 1'b0, "R4 capture mode level", pwm_out, 0);
        cap_in = 1'b1;
        capture_one("R8 rising capture");
        rd16(3'd3, t0);
        cap_in = 1'b0;
        repeat (5) begin step(); if (capture_flag) quiet = 0; end
        rd16(3'd3, t);
        chk(quiet && t == t0, "R8 falling edge ignored", t, t0);
        wr(3'd0, 8'h25);
        quiet = 1;
        cap_in = 1'b1;
        repeat (5) begin step(); if (capture_flag) quiet = 0; end
        chk(quiet, "R8 rising edge ignored", quiet, 1);
        cap_in = 1'b0;
        capture_one("R8 falling capture");
        wr(3'd0, 8'h00);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_limit_regs();
        t_continuous();
        t_buffered();
        t_compare();
        t_capture();
        finished = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule